// File: doc/BRIEF.md
# SPI Word-Packing Data FIFO

This block sits between a 32-bit register-bus data port and a byte-serial SPI shifter. On the transmit side, each bus write of one word is split into bytes and queued in a 32-byte buffer. The shifter drains these bytes one at a time through a valid/ready handshake. On the receive side, bytes from the shifter are queued in a second 32-byte buffer. Each bus read takes them back out as one word. Clock generation and chip-select control belong to other blocks.

A transfer starts when a byte count (0 to 32) is loaded. The count bounds how many bytes the transmit side accepts from the bus and how many bytes the receive side accepts from the shifter, so the last word of a transfer may be partial. Four configuration inputs set the byte order within a word and the bit order within a byte, separately for each direction. Two sticky flags report a dropped write and a read with nothing to deliver. A software reset input returns the block to its idle state.

Convention for the shifter side: bit 7 of each byte on the shifter port is the first bit on the wire. Byte lane k of a word is bits [8k+7:8k].

Top module: `spi_word_fifo`

## Requirements
- R1: After `rst_n` is released, or one cycle after `soft_rst` is asserted, the block is idle: both buffers are empty, the byte count is 0, `ovf_flag` and `udf_flag` are 0, `rd_data` is 0, `tx_valid`, `rx_ready` and `rx_word_avail` are 0.
- R2: A cycle with `len_we` high empties both buffers, restarts the transfer counters and loads the byte count from `len_val`; a value above 32 is taken as 32. The flags are left unchanged.
- R3: A write on `wr_en` queues min(4, count minus bytes already queued) bytes, taken from the low-order lanes. `tx_valid` is high exactly while the transmit buffer holds a byte, and a `tx_valid && tx_ready` cycle removes the front byte.
- R4: With `tx_byte_swap` = 0, lane 0 of a written word goes out first. With `tx_byte_swap` = 1, the order of the valid lanes is reversed, so a partial word with n valid bytes sends lane n-1 first.
- R5: With `tx_msb_first` = 1, a byte appears on `tx_data` unchanged. With `tx_msb_first` = 0, the byte's bits are reversed, so bit 0 goes out first.
- R6: A write is dropped and `ovf_flag` is set when fewer than 4 bytes of the transmit buffer are free, or when the byte count is used up. The flag stays set until `soft_rst`.
- R7: `rx_ready` is high when the receive buffer holds fewer than 32 bytes and fewer bytes than the count have been accepted. An accepted byte is stored unchanged if `rx_msb_first` = 1 and bit-reversed if it is 0.
- R8: `rx_word_avail` is high when the receive buffer holds 4 or more bytes, or holds at least one byte and all counted bytes have arrived.
- R9: A read on `rd_en` while `rx_word_avail` is high removes min(4, bytes held) bytes and presents them on `rd_data` from the next cycle. With `rx_byte_swap` = 0, the first received byte goes in lane 0. With `rx_byte_swap` = 1, the order is reversed within the n valid lanes. Lanes n and above are 0.
- R10: A read while `rx_word_avail` is low loads 0 into `rd_data`, sets the sticky `udf_flag` and leaves the receive buffer unchanged.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Software reset pulse |
| len_we | input | 1 | Load byte count and start a new transfer |
| len_val | input | 6 | Byte count to load (values above 32 saturate) |
| tx_byte_swap | input | 1 | Reverse byte order of transmit words |
| tx_msb_first | input | 1 | Transmit bytes MSB first (else bit-reversed) |
| rx_byte_swap | input | 1 | Reverse byte order of receive words |
| rx_msb_first | input | 1 | Receive bytes MSB first (else bit-reversed) |
| wr_en | input | 1 | Bus write of one transmit word |
| wr_data | input | 32 | Transmit word |
| rd_en | input | 1 | Bus read of one receive word |
| rd_data | output | 32 | Receive word, valid the cycle after the read |
| rx_word_avail | output | 1 | A receive word (full or final partial) is ready |
| tx_valid | output | 1 | Transmit byte available to the shifter |
| tx_data | output | 8 | Transmit byte, bit 7 first on the wire |
| tx_ready | input | 1 | Shifter takes the transmit byte |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_data | input | 8 | Received byte, bit 7 first on the wire |
| rx_ready | output | 1 | Block accepts the received byte |
| ovf_flag | output | 1 | Sticky: a transmit write was dropped |
| udf_flag | output | 1 | Sticky: a read found no word |

## Verification
The transmit path is exercised with full words under each byte-order and bit-order setting, and with a partial final word. These cases separate lane reversal over all four lanes from reversal over only the valid lanes, and reveal any stale upper-lane bytes. The receive path is tested with exactly four bytes, five bytes (a full word then a one-byte remainder) and three bytes with swapping. These cases distinguish the availability rule for full words from the one for final partial words. Further patterns cover reads and writes at the edges of the count, an oversized count, and a stalled shifter. Phases of mixed traffic, with writes, reads and both handshakes toggling together, are compared cycle by cycle against a queue model.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;
  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] bit_rev8(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
// Circular byte buffer: pushes up to PUSH_LANES and pops up to POP_LANES bytes per cycle.
// DEPTH must be a power of two (pointers wrap naturally).
module spi_byte_fifo #(
  parameter int DEPTH      = 32,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES  = 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int PNW = $clog2(PUSH_LANES + 1),
  localparam int ONW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [PNW-1:0]          push_n,
  input  logic [PUSH_LANES*8-1:0] push_data,
  input  logic [ONW-1:0]          pop_n,
  output logic [POP_LANES*8-1:0]  peek,
  output logic [CW-1:0]           level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_LANES; k++) begin
      if (!flush && (PNW'(k) < push_n)) mem[wr_q + AW'(k)] <= push_data[k*8 +: 8];
    end
  end

  always_comb begin
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wr_q + AW'(push_n);
      rd_d  = rd_q + AW'(pop_n);
      cnt_d = cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
    assign peek[g*8 +: 8] = mem[rd_q + AW'(g)];
  end

  assign level = cnt_q;
endmodule

// File: rtl/spi_tx_unpack.sv
// Transmit side: splits bus words into ordered bytes and hands them to the shifter.
module spi_tx_unpack import spi_wf_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1),
  localparam int LW = $clog2(LANES),
  localparam int WW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_err,
  input  logic [CW-1:0] len,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  input  logic          byte_swap,
  input  logic          msb_first,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          ovf,
  output logic [CW-1:0] level
);
  logic [CW-1:0] pushed_q, pushed_d, remain;
  logic [NW-1:0] n, push_n;
  logic [WW-1:0] push_bytes;
  logic [LW-1:0] sel;
  logic [7:0]    b;
  logic          accept, pop, ovf_q, ovf_d;

  assign remain = len - pushed_q;
  assign n      = (remain >= CW'(LANES)) ? NW'(LANES) : NW'(remain);
  assign accept = wr_en && !flush && (n != '0) && (level <= CW'(DEPTH - LANES));
  assign push_n = accept ? n : '0;
  assign pop    = tx_valid && tx_ready && !flush;

  always_comb begin
    push_bytes = '0;
    sel        = '0;
    b          = '0;
    for (int k = 0; k < LANES; k++) begin
      sel = byte_swap ? LW'(n - NW'(k) - NW'(1)) : LW'(k);
      b   = wr_data[sel*8 +: 8];
      if (!msb_first) b = bit_rev8(b);
      if (NW'(k) < n) push_bytes[k*8 +: 8] = b;
    end
  end

  always_comb begin
    pushed_d = flush ? '0 : pushed_q + CW'(push_n);
    if (clr_err)                     ovf_d = 1'b0;
    else if (wr_en && !flush && !accept) ovf_d = 1'b1;
    else                             ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pushed_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      pushed_q <= pushed_d;
      ovf_q    <= ovf_d;
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(push_n), .push_data(push_bytes),
    .pop_n(pop), .peek(tx_data), .level(level)
  );

  assign tx_valid = (level != '0);
  assign ovf      = ovf_q;
endmodule

// File: rtl/spi_rx_pack.sv
// Receive side: collects shifter bytes and packs them into bus words.
module spi_rx_pack import spi_wf_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1),
  localparam int LW = $clog2(LANES),
  localparam int WW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_err,
  input  logic [CW-1:0] len,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          byte_swap,
  input  logic          msb_first,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data,
  output logic          word_avail,
  output logic          udf,
  output logic [CW-1:0] level
);
  logic [CW-1:0] got_q, got_d;
  logic [NW-1:0] n, pop_n;
  logic [WW-1:0] peek, packed_w, rd_q, rd_d;
  logic [7:0]    in_byte;
  logic [LW-1:0] src;
  logic          take, pop, rd_ok, udf_q, udf_d;

  assign rx_ready   = (level < CW'(DEPTH)) && (got_q < len);
  assign take       = rx_valid && rx_ready && !flush;
  assign in_byte    = msb_first ? rx_data : bit_rev8(rx_data);
  assign word_avail = (level >= CW'(LANES)) || ((level != '0) && (got_q == len));
  assign n          = (level >= CW'(LANES)) ? NW'(LANES) : NW'(level);
  assign rd_ok      = rd_en && !flush;
  assign pop        = rd_ok && word_avail;
  assign pop_n      = pop ? n : '0;

  always_comb begin
    packed_w = '0;
    src      = '0;
    for (int l = 0; l < LANES; l++) begin
      src = byte_swap ? LW'(n - NW'(l) - NW'(1)) : LW'(l);
      if (NW'(l) < n) packed_w[l*8 +: 8] = peek[src*8 +: 8];
    end
  end

  always_comb begin
    got_d = flush ? '0 : got_q + CW'(take);
    if (clr_err)    rd_d = '0;
    else if (pop)   rd_d = packed_w;
    else if (rd_ok) rd_d = '0;
    else            rd_d = rd_q;
    if (clr_err)                  udf_d = 1'b0;
    else if (rd_ok && !word_avail) udf_d = 1'b1;
    else                          udf_d = udf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
      rd_q  <= '0;
      udf_q <= 1'b0;
    end else begin
      got_q <= got_d;
      rd_q  <= rd_d;
      udf_q <= udf_d;
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(take), .push_data(in_byte),
    .pop_n(pop_n), .peek(peek), .level(level)
  );

  assign rd_data = rd_q;
  assign udf     = udf_q;
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int WW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          len_we,
  input  logic [CW-1:0] len_val,
  input  logic          tx_byte_swap,
  input  logic          tx_msb_first,
  input  logic          rx_byte_swap,
  input  logic          rx_msb_first,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data,
  output logic          rx_word_avail,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          ovf_flag,
  output logic          udf_flag
);
  logic          rst_meta, rst_sync;
  logic [CW-1:0] len_q, len_d, tx_level, rx_level;
  logic          flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  assign flush = soft_rst || len_we;

  always_comb begin
    if (soft_rst)    len_d = '0;
    else if (len_we) len_d = (len_val > CW'(DEPTH)) ? CW'(DEPTH) : len_val;
    else             len_d = len_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) len_q <= '0;
    else           len_q <= len_d;
  end

  spi_tx_unpack #(.DEPTH(DEPTH), .LANES(LANES)) u_tx (
    .clk(clk), .rst_n(rst_sync), .flush(flush), .clr_err(soft_rst), .len(len_q),
    .wr_en(wr_en), .wr_data(wr_data), .byte_swap(tx_byte_swap), .msb_first(tx_msb_first),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .ovf(ovf_flag), .level(tx_level)
  );

  spi_rx_pack #(.DEPTH(DEPTH), .LANES(LANES)) u_rx (
    .clk(clk), .rst_n(rst_sync), .flush(flush), .clr_err(soft_rst), .len(len_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .byte_swap(rx_byte_swap), .msb_first(rx_msb_first),
    .rd_en(rd_en), .rd_data(rd_data), .word_avail(rx_word_avail),
    .udf(udf_flag), .level(rx_level)
  );
endmodule

// File: rtl/spi_word_fifo_chk.sv
module spi_word_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync,
  input logic             soft_rst,
  input logic             len_we,
  input logic             wr_en,
  input logic             rd_en,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_ready,
  input logic             rx_word_avail,
  input logic [LANES*8-1:0] rd_data,
  input logic             ovf_flag,
  input logic             udf_flag,
  input logic [CW-1:0]    tx_level,
  input logic [CW-1:0]    rx_level
);
  // R1
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    soft_rst |=> (!tx_valid && !rx_word_avail && !rx_ready && !ovf_flag && !udf_flag && rd_data == '0));

  // R2
  len_load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (len_we && !soft_rst) |=> (!tx_valid && !rx_word_avail));

  // R6
  full_write_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (wr_en && !soft_rst && !len_we && tx_level > CW'(DEPTH - LANES)) |=> ovf_flag);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (ovf_flag && !soft_rst) |=> ovf_flag);

  // R10
  empty_read_udf_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (rd_en && !soft_rst && !len_we && !rx_word_avail) |=> (udf_flag && rd_data == '0));

  // R10
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (udf_flag && !soft_rst) |=> udf_flag);

  // R7
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (rx_level == CW'(DEPTH)) |-> !rx_ready);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    (tx_valid && !tx_ready && !soft_rst && !len_we) |=> (tx_valid && $stable(tx_data)));
endmodule

bind spi_word_fifo spi_word_fifo_chk #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW)) u_chk (.*);

// File: tb/tb_spi_word_fifo.sv
`timescale 1ns/1ps
module tb_spi_word_fifo;
  localparam int  CLK_NS = 8;
  localparam int  DEPTH  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, len_we = 0;
  logic [5:0] len_val = '0;
  logic tx_byte_swap = 0, tx_msb_first = 1, rx_byte_swap = 0, rx_msb_first = 1;
  logic wr_en = 0, rd_en = 0, tx_ready = 0, rx_valid = 0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rx_data = '0;
  logic [31:0] rd_data;
  logic rx_word_avail, tx_valid, rx_ready, ovf_flag, udf_flag;
  logic [7:0] tx_data;

  always #(CLK_NS/2) clk = ~clk;

  spi_word_fifo dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .len_we(len_we), .len_val(len_val),
    .tx_byte_swap(tx_byte_swap), .tx_msb_first(tx_msb_first),
    .rx_byte_swap(rx_byte_swap), .rx_msb_first(rx_msb_first),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rx_word_avail(rx_word_avail), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  int unsigned n_checks = 0, n_errors = 0;
  bit cmp_on = 0;
  logic [7:0] cap[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] flip(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] mtx[$], mrx[$];
  int mlen = 0, mpushed = 0, mgot = 0;
  bit movf = 0, mudf = 0;
  logic [31:0] mrd = '0;
  int tsz, rsz, n, lane;
  bit ravail, rrdy;
  logic [7:0] b;
  logic [31:0] w;

  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      mtx.delete(); mrx.delete();
      mlen = 0; mpushed = 0; mgot = 0; movf = 0; mudf = 0; mrd = '0;
    end else if (len_we) begin
      mtx.delete(); mrx.delete();
      mlen = (int'(len_val) > DEPTH) ? DEPTH : int'(len_val);
      mpushed = 0; mgot = 0;
    end else begin
      tsz = mtx.size(); rsz = mrx.size();
      ravail = (rsz >= 4) || (rsz > 0 && mgot == mlen);
      rrdy   = (rsz < DEPTH) && (mgot < mlen);
      if (tsz > 0 && tx_ready) void'(mtx.pop_front());
      if (wr_en) begin
        n = (mlen - mpushed > 4) ? 4 : mlen - mpushed;
        if (tsz > DEPTH - 4 || n == 0) movf = 1;
        else begin
          for (int k = 0; k < n; k++) begin
            lane = tx_byte_swap ? n - 1 - k : k;
            b = wr_data[8*lane +: 8];
            mtx.push_back(tx_msb_first ? b : flip(b));
          end
          mpushed += n;
        end
      end
      if (rd_en) begin
        if (ravail) begin
          n = (rsz > 4) ? 4 : rsz;
          w = '0;
          for (int k = 0; k < n; k++) begin
            lane = rx_byte_swap ? n - 1 - k : k;
            w[8*lane +: 8] = mrx.pop_front();
          end
          mrd = w;
        end else begin
          mrd = '0; mudf = 1;
        end
      end
      if (rx_valid && rrdy) begin
        mrx.push_back(rx_msb_first ? rx_data : flip(rx_data));
        mgot++;
      end
    end
  end

  // compare on every falling edge; capture shifter-side handshakes
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 tx_valid", {31'd0, tx_valid}, {31'd0, mtx.size() > 0});
      if (mtx.size() > 0) chk("R3 tx_data", {24'd0, tx_data}, {24'd0, mtx[0]});
      chk("R7 rx_ready", {31'd0, rx_ready}, {31'd0, (mrx.size() < DEPTH) && (mgot < mlen)});
      chk("R8 rx_word_avail", {31'd0, rx_word_avail},
          {31'd0, (mrx.size() >= 4) || (mrx.size() > 0 && mgot == mlen)});
      chk("R9 rd_data", rd_data, mrd);
      chk("R6 ovf_flag", {31'd0, ovf_flag}, {31'd0, movf});
      chk("R10 udf_flag", {31'd0, udf_flag}, {31'd0, mudf});
    end
    if (tx_valid && tx_ready) cap.push_back(tx_data);
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(posedge clk); #2; endtask
  task automatic load(input int l); len_val = 6'(l); len_we = 1; step(); len_we = 0; endtask
  task automatic sreset(); soft_rst = 1; step(); soft_rst = 0; endtask
  task automatic wr(input logic [31:0] d); wr_data = d; wr_en = 1; step(); wr_en = 0; endtask
  task automatic send(input logic [7:0] d); rx_data = d; rx_valid = 1; step(); rx_valid = 0; endtask
  task automatic rd(); rd_en = 1; step(); rd_en = 0; endtask
  task automatic drain(input int cycles);
    tx_ready = 1; repeat (cycles) step(); tx_ready = 0;
  endtask
  task automatic chk_cap(input string tag, input int idx, input logic [7:0] exp);
    if (idx < cap.size()) chk(tag, {24'd0, cap[idx]}, {24'd0, exp});
    else chk(tag, 32'hFFFF_FFFF, {24'd0, exp});
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) step();
    cmp_on = 1;
    // R1 reset state
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 0);
    chk("R1 flags", {30'd0, ovf_flag, udf_flag}, 0);
    chk("R1 rd_data", rd_data, 0);

    // R3 R4 R5: full words, natural order
    load(8); wr(32'h4433_2211); wr(32'h8877_6655);
    cap.delete(); drain(10);
    chk("R3 tx count", cap.size(), 8);
    for (int i = 0; i < 8; i++) chk_cap("R4 lane0-first", i, 8'(8'h11 * (i + 1)));

    // R4 swapped with partial final word
    tx_byte_swap = 1; load(6); wr(32'h4433_2211); wr(32'h0000_BBAA);
    cap.delete(); drain(8);
    chk("R4 tx count", cap.size(), 6);
    chk_cap("R4 swap b0", 0, 8'h44); chk_cap("R4 swap b3", 3, 8'h11);
    chk_cap("R4 partial b4", 4, 8'hBB); chk_cap("R4 partial b5", 5, 8'hAA);

    // R5 LSB-first bit order
    tx_byte_swap = 0; tx_msb_first = 0; load(2); wr(32'h0000_C001);
    cap.delete(); drain(4);
    chk_cap("R5 rev b0", 0, 8'h80); chk_cap("R5 rev b1", 1, 8'h03);
    tx_msb_first = 1;

    // R3 R6 count exhausted
    load(3); wr(32'h0033_2211);
    chk("R6 no ovf", {31'd0, ovf_flag}, 0);
    wr(32'hDEAD_BEEF);
    chk("R6 ovf set", {31'd0, ovf_flag}, 1);
    cap.delete(); drain(5);
    chk("R3 only count", cap.size(), 3);
    chk_cap("R3 last byte", 2, 8'h33);
    load(4);
    chk("R2 flag kept", {31'd0, ovf_flag}, 1);
    sreset();
    chk("R1 soft ovf clr", {31'd0, ovf_flag}, 0);

    // R2 clamp of oversized count
    load(40);
    for (int i = 0; i < 8; i++) wr(32'h0302_0100 + 32'h0404_0404 * i);
    chk("R6 full ok", {31'd0, ovf_flag}, 0);
    cap.delete(); drain(36);
    chk("R2 tx count", cap.size(), 32);
    chk_cap("R2 byte31", 31, 8'd31);
    wr(32'h1234_5678);
    chk("R2 clamp ovf", {31'd0, ovf_flag}, 1);
    sreset();

    // R7 R8 R9 receive, partial word
    load(5);
    send(8'h01); send(8'h02); send(8'h03);
    chk("R8 not yet", {31'd0, rx_word_avail}, 0);
    send(8'h04); send(8'h05);
    chk("R7 count reached", {31'd0, rx_ready}, 0);
    chk("R8 avail", {31'd0, rx_word_avail}, 1);
    rd(); chk("R9 word", rd_data, 32'h0403_0201);
    chk("R8 partial avail", {31'd0, rx_word_avail}, 1);
    rd(); chk("R9 partial", rd_data, 32'h0000_0005);
    chk("R8 empty", {31'd0, rx_word_avail}, 0);

    rx_byte_swap = 1; load(3); send(8'hAA); send(8'hBB); send(8'hCC);
    rd(); chk("R9 swap partial", rd_data, 32'h00AA_BBCC);
    load(4); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    rd(); chk("R9 swap full", rd_data, 32'h0102_0304);
    rx_byte_swap = 0; rx_msb_first = 0;
    load(1); send(8'h01);
    rd(); chk("R7 bit reverse", rd_data, 32'h0000_0080);
    rx_msb_first = 1;

    // R10 underflow
    sreset(); rd();
    chk("R10 zero", rd_data, 0);
    chk("R10 udf", {31'd0, udf_flag}, 1);
    load(2); send(8'h5A); rd();
    chk("R10 early read", rd_data, 0);
    send(8'hA5); rd();
    chk("R10 buffer kept", rd_data, 32'h0000_A55A);
    sreset();

    // R7 receive buffer full
    load(32);
    for (int i = 0; i < 32; i++) send(8'(i));
    chk("R7 full stall", {31'd0, rx_ready}, 0);
    rd(); chk("R9 first of full", rd_data, 32'h0302_0100);

    // R11 stalled shifter
    load(2); wr(32'h0000_BEEF);
    repeat (3) begin
      step(); chk("R11 hold", {24'd0, tx_data}, 32'h0000_00EF);
    end
    cap.delete(); drain(3);
    chk_cap("R11 second", 1, 8'hBE);

    // mixed traffic, compared every cycle against the model
    for (int r = 0; r < 4; r++) begin
      tx_byte_swap = r[0]; tx_msb_first = r[1];
      rx_byte_swap = r[1]; rx_msb_first = r[0];
      load(13 + 6 * r);
      for (int c = 0; c < 80; c++) begin
        wr_en    = ($urandom % 3) == 0;
        wr_data  = $urandom;
        rd_en    = ($urandom % 4) == 0;
        tx_ready = $urandom % 2;
        rx_valid = $urandom % 2;
        rx_data  = 8'($urandom);
        step();
      end
      wr_en = 0; rd_en = 0; tx_ready = 0; rx_valid = 0;
      step();
    end
    step();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule